// File: doc/BRIEF.md
# Descriptor-Chained Transmit Packet Mover

This block moves one transmit packet at a time from main memory into a byte-wide staging FIFO. A packet is submitted as a pointer to its packet descriptor. The block reads that descriptor to learn the packet size, the completion queue and the first buffer descriptor. It then walks a linked list of buffer descriptors. Each buffer is cut into read bursts of no more than 64 bytes, issued on a simple valid/ready memory-read port. The bytes that come back are written into the staging FIFO.

When the bytes moved reach the packet size, or the chain of buffers ends, the block offers the packet descriptor pointer on a completion port. The completion carries the queue manager and queue number taken from the packet descriptor. Descriptors are read through a separate port that returns a whole 96-bit descriptor in one beat. Bursts and the bytes that answer them are held back for as long as the staging FIFO reports full.

Top module: `dmac_chain_tx`

## Requirements
- R1: A read burst never asks for more than 64 bytes, and a buffer with at least 64 bytes left is read in full 64-byte bursts (a 256-byte buffer takes exactly four bursts of 64).
- R2: When fewer than 64 bytes of a buffer remain, the final burst asks for exactly the remaining count (for example 32).
- R3: Burst addresses start at the buffer address and advance by the length of each burst. Every returned byte is written to the staging FIFO in the order it arrives.
- R4: After a buffer is used up, the block reads the buffer descriptor at that buffer's next pointer and only then issues further bursts. A next pointer of zero ends the chain and leads to completion.
- R5: A buffer descriptor with length zero produces no burst; the chain continues with its next pointer.
- R6: At the end of a burst that brings the bytes moved to or past the packet size, the block completes and reads no further buffer descriptors. A packet size of zero completes right after the packet descriptor is read, with no buffer descriptor read.
- R7: The completion port presents the packet descriptor pointer, queue manager and queue number. It holds them steady with valid high until ready is seen.
- R8: While `fifo_full` is high, no burst request is presented and no returned byte is accepted or written.
- R9: `busy` rises the cycle after a submission is accepted and falls the cycle after the completion is accepted. `sub_ready` is high only while the block is not busy.
- R10: After reset, `busy`, all request valids, `cmp_valid` and `fifo_wr_en` are low and `sub_ready` is high.
- R11: Packet descriptor layout: size in bits 15:0, queue manager in 17:16, queue number in 29:18, first buffer descriptor pointer in 63:32. Buffer descriptor layout: buffer address in 31:0, length in 47:32, next pointer in 95:64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | 1 | Packet submission valid |
| sub_ptr | input | 32 | Packet descriptor pointer |
| sub_ready | output | 1 | Block can take a packet |
| desc_req_valid | output | 1 | Descriptor read request |
| desc_req_ready | input | 1 | Descriptor request accepted |
| desc_req_addr | output | 32 | Descriptor address |
| desc_rsp_valid | input | 1 | Descriptor data returned |
| desc_rsp_data | input | 96 | Descriptor contents |
| rd_req_valid | output | 1 | Burst read request |
| rd_req_ready | input | 1 | Burst request accepted |
| rd_req_addr | output | 32 | Burst start address |
| rd_req_len | output | 7 | Burst length in bytes, 1 to 64 |
| rd_rsp_valid | input | 1 | Returned data byte valid |
| rd_rsp_ready | output | 1 | Block takes a data byte |
| rd_rsp_data | input | 8 | Returned data byte |
| fifo_full | input | 1 | Staging FIFO cannot take data |
| fifo_wr_en | output | 1 | Staging FIFO write |
| fifo_wr_data | output | 8 | Staging FIFO write byte |
| cmp_valid | output | 1 | Completion push valid |
| cmp_ready | input | 1 | Completion queue accepts |
| cmp_qmgr | output | 2 | Completion queue manager |
| cmp_qnum | output | 12 | Completion queue number |
| cmp_ptr | output | 32 | Completed packet descriptor pointer |
| busy | output | 1 | Packet in progress |

## Verification
The hardest case to reach is a packet whose size runs out partway through a chain, while later buffer descriptors are still linked. The block must then stop without fetching them. A table entry builds a three-buffer chain whose size is met at the end of the second buffer, and the bench counts descriptor reads. Zero-length buffers, a size of zero and bursts stalled by a full FIFO are placed in the same table and in directed runs. In those runs the full flag or completion ready is held for many cycles.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int ADDR_W    = 32;
    localparam int LEN_W     = 16;
    localparam int QM_W      = 2;
    localparam int QN_W      = 12;
    localparam int DESC_W    = 96;
    localparam int BYTE_W    = 8;
    localparam int MAX_BURST = 64;
    localparam int BURST_W   = $clog2(MAX_BURST + 1);
    localparam int MOVED_W   = LEN_W + 1;

    // packet descriptor field positions
    localparam int PD_SIZE_LO  = 0;
    localparam int PD_QM_LO    = PD_SIZE_LO + LEN_W;
    localparam int PD_QN_LO    = PD_QM_LO + QM_W;
    localparam int PD_FIRST_LO = 32;
    // buffer descriptor field positions
    localparam int BD_ADDR_LO  = 0;
    localparam int BD_LEN_LO   = 32;
    localparam int BD_NEXT_LO  = 64;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PD_REQ, ST_PD_WAIT, ST_BD_REQ,
        ST_BD_WAIT, ST_RD_REQ, ST_RD_DATA, ST_DONE
    } mover_st_e;

    typedef struct packed {
        mover_st_e           st;
        logic [ADDR_W-1:0]   pd_ptr;
        logic [ADDR_W-1:0]   desc_addr;
        logic [LEN_W-1:0]    size;
        logic [QM_W-1:0]     qm;
        logic [QN_W-1:0]     qn;
        logic [MOVED_W-1:0]  moved;
        logic [ADDR_W-1:0]   buf_addr;
        logic [LEN_W-1:0]    buf_rem;
        logic [ADDR_W-1:0]   next_ptr;
        logic [BURST_W-1:0]  beats;
    } mover_regs_t;
endpackage

// File: rtl/dmac_desc_unpack.sv
module dmac_desc_unpack
    import dmac_pkg::*;
(
    input  logic [DESC_W-1:0] word,
    output logic [LEN_W-1:0]  pd_size,
    output logic [QM_W-1:0]   pd_qm,
    output logic [QN_W-1:0]   pd_qn,
    output logic [ADDR_W-1:0] pd_first,
    output logic [ADDR_W-1:0] bd_addr,
    output logic [LEN_W-1:0]  bd_len,
    output logic [ADDR_W-1:0] bd_next
);
    assign pd_size  = word[PD_SIZE_LO  +: LEN_W];
    assign pd_qm    = word[PD_QM_LO    +: QM_W];
    assign pd_qn    = word[PD_QN_LO    +: QN_W];
    assign pd_first = word[PD_FIRST_LO +: ADDR_W];
    assign bd_addr  = word[BD_ADDR_LO  +: ADDR_W];
    assign bd_len   = word[BD_LEN_LO   +: LEN_W];
    assign bd_next  = word[BD_NEXT_LO  +: ADDR_W];
endmodule

// File: rtl/dmac_burst_len.sv
module dmac_burst_len
    import dmac_pkg::*;
(
    input  logic [LEN_W-1:0]   remain,
    output logic [BURST_W-1:0] blen
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_BURST);

    assign blen = (remain >= CAP) ? BURST_W'(MAX_BURST) : BURST_W'(remain);
endmodule

// File: rtl/dmac_chain_tx.sv
module dmac_chain_tx
    import dmac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sub_valid,
    input  logic [ADDR_W-1:0]  sub_ptr,
    output logic               sub_ready,
    output logic               desc_req_valid,
    input  logic               desc_req_ready,
    output logic [ADDR_W-1:0]  desc_req_addr,
    input  logic               desc_rsp_valid,
    input  logic [DESC_W-1:0]  desc_rsp_data,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [ADDR_W-1:0]  rd_req_addr,
    output logic [BURST_W-1:0] rd_req_len,
    input  logic               rd_rsp_valid,
    output logic               rd_rsp_ready,
    input  logic [BYTE_W-1:0]  rd_rsp_data,
    input  logic               fifo_full,
    output logic               fifo_wr_en,
    output logic [BYTE_W-1:0]  fifo_wr_data,
    output logic               cmp_valid,
    input  logic               cmp_ready,
    output logic [QM_W-1:0]    cmp_qmgr,
    output logic [QN_W-1:0]    cmp_qnum,
    output logic [ADDR_W-1:0]  cmp_ptr,
    output logic               busy
);
    mover_regs_t r_q, r_d;

    logic [LEN_W-1:0]   pd_size, bd_len;
    logic [QM_W-1:0]    pd_qm;
    logic [QN_W-1:0]    pd_qn;
    logic [ADDR_W-1:0]  pd_first, bd_addr, bd_next;
    logic [BURST_W-1:0] burst_len;
    logic               beat;
    logic [MOVED_W-1:0] moved_inc;
    logic [LEN_W-1:0]   rem_dec;

    dmac_desc_unpack u_unpack (
        .word     (desc_rsp_data),
        .pd_size  (pd_size),
        .pd_qm    (pd_qm),
        .pd_qn    (pd_qn),
        .pd_first (pd_first),
        .bd_addr  (bd_addr),
        .bd_len   (bd_len),
        .bd_next  (bd_next)
    );

    dmac_burst_len u_split (
        .remain (r_q.buf_rem),
        .blen   (burst_len)
    );

    assign sub_ready      = (r_q.st == ST_IDLE);
    assign busy           = (r_q.st != ST_IDLE);
    assign desc_req_valid = (r_q.st == ST_PD_REQ) || (r_q.st == ST_BD_REQ);
    assign desc_req_addr  = r_q.desc_addr;
    assign rd_req_valid   = (r_q.st == ST_RD_REQ) && !fifo_full;
    assign rd_req_addr    = r_q.buf_addr;
    assign rd_req_len     = burst_len;
    assign rd_rsp_ready   = (r_q.st == ST_RD_DATA) && !fifo_full;
    assign beat           = rd_rsp_valid && rd_rsp_ready;
    assign fifo_wr_en     = beat;
    assign fifo_wr_data   = rd_rsp_data;
    assign cmp_valid      = (r_q.st == ST_DONE);
    assign cmp_qmgr       = r_q.qm;
    assign cmp_qnum       = r_q.qn;
    assign cmp_ptr        = r_q.pd_ptr;
    assign moved_inc      = r_q.moved + MOVED_W'(1);
    assign rem_dec        = r_q.buf_rem - LEN_W'(1);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: if (sub_valid) begin
                r_d.pd_ptr    = sub_ptr;
                r_d.desc_addr = sub_ptr;
                r_d.moved     = '0;
                r_d.st        = ST_PD_REQ;
            end
            ST_PD_REQ: if (desc_req_ready) r_d.st = ST_PD_WAIT;
            ST_PD_WAIT: if (desc_rsp_valid) begin
                r_d.size      = pd_size;
                r_d.qm        = pd_qm;
                r_d.qn        = pd_qn;
                r_d.desc_addr = pd_first;
                r_d.st        = (pd_size == '0) ? ST_DONE : ST_BD_REQ;
            end
            ST_BD_REQ: if (desc_req_ready) r_d.st = ST_BD_WAIT;
            ST_BD_WAIT: if (desc_rsp_valid) begin
                r_d.buf_addr = bd_addr;
                r_d.buf_rem  = bd_len;
                r_d.next_ptr = bd_next;
                if (bd_len != '0) begin
                    r_d.st = ST_RD_REQ;
                end else if (bd_next == '0) begin
                    r_d.st = ST_DONE;
                end else begin
                    r_d.desc_addr = bd_next;
                    r_d.st        = ST_BD_REQ;
                end
            end
            ST_RD_REQ: if (rd_req_valid && rd_req_ready) begin
                r_d.beats = burst_len;
                r_d.st    = ST_RD_DATA;
            end
            ST_RD_DATA: if (beat) begin
                r_d.buf_addr = r_q.buf_addr + ADDR_W'(1);
                r_d.buf_rem  = rem_dec;
                r_d.moved    = moved_inc;
                r_d.beats    = r_q.beats - BURST_W'(1);
                if (r_q.beats == BURST_W'(1)) begin
                    if (moved_inc >= MOVED_W'(r_q.size)) begin
                        r_d.st = ST_DONE;
                    end else if (rem_dec != '0) begin
                        r_d.st = ST_RD_REQ;
                    end else if (r_q.next_ptr == '0) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.desc_addr = r_q.next_ptr;
                        r_d.st        = ST_BD_REQ;
                    end
                end
            end
            ST_DONE: if (cmp_ready) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R1: requested burst is never empty and never above the cap
    p_burst_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_len != '0) && (rd_req_len <= BURST_W'(MAX_BURST)));

    // R8: no burst request while staging FIFO is full
    p_hold_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !rd_req_valid && !fifo_wr_en);

    // R7: completion stays presented and unchanged until taken
    p_cmp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && !cmp_ready |=> cmp_valid && $stable(cmp_ptr)
                                   && $stable(cmp_qnum) && $stable(cmp_qmgr));

    // R9: a submission is only taken while idle, and busy follows it
    p_busy_after_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid && sub_ready |=> busy);

    // R9: busy drops after completion is accepted
    p_idle_after_cmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_ready |=> !busy);

    // R3: only one kind of request is outstanding at once
    p_one_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_req_valid && rd_req_valid) && !(cmp_valid && rd_rsp_ready));
endmodule

// File: tb/dmac_chain_tx_test.sv
module dmac_chain_tx_test;
    localparam int BD_BASE = 32'h800;
    localparam int NV = 5;
    // size, nbuf, len0, len1, len2, qmgr, qnum, stall
    localparam int VT [0:NV-1][0:7] = '{
        '{256, 1, 256,  0,   0, 1, 12'h101, 0},
        '{352, 2, 256, 96,   0, 2, 12'h2a5, 1},
        '{100, 3,  40,  0,  60, 3, 12'h033, 0},
        '{128, 3,  64, 64, 200, 0, 12'hfff, 1},
        '{200, 2,  50, 30,   0, 1, 12'h400, 0}
    };

    logic        clk = 0, rst_n = 0;
    logic        sub_valid = 0;
    logic [31:0] sub_ptr = 0;
    logic        sub_ready;
    logic        desc_req_valid, desc_req_ready = 1;
    logic [31:0] desc_req_addr;
    logic        desc_rsp_valid = 0;
    logic [95:0] desc_rsp_data = 0;
    logic        rd_req_valid, rd_req_ready = 0;
    logic [31:0] rd_req_addr;
    logic [6:0]  rd_req_len;
    logic        rd_rsp_valid = 0, rd_rsp_ready;
    logic [7:0]  rd_rsp_data = 0;
    logic        fifo_full = 0, fifo_wr_en;
    logic [7:0]  fifo_wr_data;
    logic        cmp_valid, cmp_ready = 1;
    logic [1:0]  cmp_qmgr;
    logic [11:0] cmp_qnum;
    logic [31:0] cmp_ptr;
    logic        busy;

    always #2.5 clk = ~clk;

    dmac_chain_tx uut (.*);

    int total = 0, bad = 0, cyc = 0;
    int g_size, g_n, g_qm, g_qn, g_pd;
    int g_len [0:2];
    bit stall_mode = 0, force_full = 0, cmp_ready_en = 1;
    int exp_blen [0:31];
    int exp_baddr [0:31];
    int n_exp, exp_desc;
    logic [7:0] exp_bytes [0:511];
    int n_bytes;
    int burst_idx, burst_err, wr_idx, data_err, desc_cnt, full_viol;
    bit cmp_seen;
    logic [31:0] seen_ptr;
    logic [11:0] seen_qn;
    logic [1:0]  seen_qm;
    bit hs_desc, hs_rd, hs_beat;
    logic [31:0] l_desc_addr, l_rd_addr;
    int l_rd_len, rem_b;
    logic [31:0] cur_a;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [95:0] lookup(logic [31:0] a);
        logic [95:0] d = '0;
        int i;
        if (a == 32'(g_pd)) begin
            d[15:0]  = 16'(g_size);
            d[17:16] = 2'(g_qm);
            d[29:18] = 12'(g_qn);
            d[63:32] = 32'(BD_BASE);
        end else begin
            i = (int'(a) - BD_BASE) >>> 4;
            if (i >= 0 && i < g_n) begin
                d[31:0]  = 32'((i + 1) << 12);
                d[47:32] = 16'(g_len[i]);
                d[95:64] = (i < g_n - 1) ? 32'(BD_BASE + 16 * (i + 1)) : 32'h0;
            end
        end
        return d;
    endfunction

    // sample handshakes away from the active edge
    always @(negedge clk) begin
        hs_desc = desc_req_valid && desc_req_ready;
        hs_rd   = rd_req_valid && rd_req_ready;
        hs_beat = rd_rsp_valid && rd_rsp_ready;
        if (hs_desc) begin
            l_desc_addr = desc_req_addr;
            desc_cnt++;
        end
        if (hs_rd) begin
            l_rd_addr = rd_req_addr;
            l_rd_len  = int'(rd_req_len);
            if (burst_idx >= n_exp || exp_blen[burst_idx] != l_rd_len
                || exp_baddr[burst_idx] != int'(rd_req_addr))
                burst_err++;
            burst_idx++;
        end
        if (fifo_wr_en) begin
            if (wr_idx >= n_bytes || exp_bytes[wr_idx] != fifo_wr_data) data_err++;
            wr_idx++;
        end
        if (fifo_full && (rd_req_valid || fifo_wr_en)) full_viol++;
        if (cmp_valid && cmp_ready) begin
            cmp_seen = 1;
            seen_ptr = cmp_ptr;
            seen_qn  = cmp_qnum;
            seen_qm  = cmp_qmgr;
        end
    end

    // memory and FIFO models drive just after each edge
    always @(posedge clk) begin
        #1;
        cyc++;
        desc_rsp_valid = hs_desc;
        desc_rsp_data  = hs_desc ? lookup(l_desc_addr) : '0;
        if (hs_beat) begin
            cur_a = cur_a + 1;
            rem_b = rem_b - 1;
        end
        if (hs_rd) begin
            cur_a = l_rd_addr;
            rem_b = l_rd_len;
        end
        rd_rsp_valid = (rem_b > 0) && (cyc % 4 != 3);
        rd_rsp_data  = cur_a[15:8] + cur_a[7:0];
        fifo_full    = force_full || (stall_mode && (cyc % 5 < 2));
        rd_req_ready = (cyc % 3 != 0);
        cmp_ready    = cmp_ready_en;
    end

    always @(negedge clk) begin
        if (cyc == 150000) begin
            chk(0, "WD", "watchdog expired", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic build_expected();
        int moved = 0;
        bit stop = (g_size == 0);
        n_exp = 0; n_bytes = 0; exp_desc = 1;
        for (int i = 0; i < g_n && !stop; i++) begin
            int rem = g_len[i];
            int off = 0;
            exp_desc++;
            while (rem > 0 && !stop) begin
                int b = (rem > 64) ? 64 : rem;
                exp_blen[n_exp]  = b;
                exp_baddr[n_exp] = ((i + 1) << 12) + off;
                n_exp++;
                for (int k = 0; k < b; k++) begin
                    exp_bytes[n_bytes] = 8'((16 * (i + 1)) + off + k);
                    n_bytes++;
                end
                off += b; rem -= b; moved += b;
                if (moved >= g_size) stop = 1;
            end
        end
    endtask

    task automatic run_packet(int sz, int n, int l0, int l1, int l2, int qm, int qn,
                              int pd, bit stall, bit hold_full, bit hold_cmp, string tag);
        g_size = sz; g_n = n; g_len[0] = l0; g_len[1] = l1; g_len[2] = l2;
        g_qm = qm; g_qn = qn; g_pd = pd;
        build_expected();
        burst_idx = 0; burst_err = 0; wr_idx = 0; data_err = 0;
        desc_cnt = 0; full_viol = 0; cmp_seen = 0;
        @(posedge clk); #1;
        stall_mode = stall; force_full = hold_full; cmp_ready_en = !hold_cmp;
        sub_valid = 1; sub_ptr = 32'(pd);
        do @(negedge clk); while (!sub_ready);
        @(posedge clk); #1;
        sub_valid = 0;
        @(negedge clk);
        chk(busy == 1, "R9", {tag, " busy after submit"}, busy, 1);
        if (hold_full) begin
            repeat (40) @(negedge clk);
            chk(wr_idx == 0 && burst_idx == 0 && !cmp_seen, "R8",
                {tag, " no traffic while full"}, wr_idx + burst_idx, 0);
            @(posedge clk); #1; force_full = 0;
        end
        if (hold_cmp) begin
            do @(negedge clk); while (!cmp_valid);
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                chk(cmp_valid && busy && cmp_ptr == 32'(pd), "R7",
                    {tag, " completion held"}, int'(cmp_ptr), pd);
            end
            @(posedge clk); #1; cmp_ready_en = 1;
        end
        for (int k = 0; k < 5000 && !cmp_seen; k++) @(negedge clk);
        chk(cmp_seen, "R6", {tag, " completion reached"}, cmp_seen, 1);
        @(negedge clk);
        chk(busy == 0 && sub_ready, "R9", {tag, " idle after completion"}, busy, 0);
        chk(burst_idx == n_exp && burst_err == 0, "R1 R2 R5",
            {tag, " burst count and lengths"}, burst_idx + 1000 * burst_err, n_exp);
        chk(wr_idx == n_bytes && data_err == 0, "R3",
            {tag, " FIFO bytes"}, wr_idx + 1000 * data_err, n_bytes);
        chk(desc_cnt == exp_desc, "R4 R6", {tag, " descriptor reads"}, desc_cnt, exp_desc);
        chk(seen_ptr == 32'(pd) && seen_qn == 12'(qn) && seen_qm == 2'(qm), "R7 R11",
            {tag, " completion fields"}, int'(seen_qn), qn);
        chk(full_viol == 0, "R8", {tag, " full respected"}, full_viol, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk(!busy && !desc_req_valid && !rd_req_valid && !cmp_valid && !fifo_wr_en && sub_ready,
            "R10", "reset state", busy, 0);
        for (int v = 0; v < NV; v++)
            run_packet(VT[v][0], VT[v][1], VT[v][2], VT[v][3], VT[v][4], VT[v][5],
                       VT[v][6], 'h40 + 16 * v, VT[v][7] != 0, 0, 0, $sformatf("vec%0d", v));
        // R6: zero size, no buffer descriptor read
        run_packet(0, 1, 64, 0, 0, 2, 12'h077, 'h3c0, 0, 0, 0, "size0");
        // R8: FIFO full held for a long stretch
        run_packet(96, 1, 96, 0, 0, 3, 12'h155, 'h3d0, 0, 1, 0, "hold_full");
        // R7: completion back-pressure
        run_packet(64, 2, 0, 64, 0, 0, 12'h0a0, 'h3e0, 1, 0, 1, "hold_cmp");
        // R2: single short burst of 32
        run_packet(32, 1, 32, 0, 0, 1, 12'h020, 'h3f0, 0, 0, 0, "short32");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule